// File: doc/BRIEF.md
# Dual-Converter Scan Sequencer

This block times a scan across two analog converter cores. Each core has its own sample-and-hold stage and an eight-way input multiplexer. A start pulse launches a scan that fills 1 to 8 result slots. The conversion list, the scan length and the pairing mode are captured when the start pulse is accepted. For each active core the block drives a channel select, a one-cycle sample strobe and a one-cycle convert strobe. It latches the 12-bit code the core returns when the conversion time has elapsed, and pulses end-of-scan after the last slot is written.

The block runs on a clock at twice the converter clock, so half-clock timing counts exactly in whole cycles. The first conversion of a scan takes 8.5 converter clocks (17 cycles). Every later conversion takes 6 converter clocks (12 cycles). In paired mode both cores sample on the same cycle and fill two slots at once, so eight results are ready after 26.5 converter clocks. With looping enabled, scans repeat back to back at the 12-cycle spacing until looping is switched off.

Top module: `scan_seq`

## Requirements
- R1: After reset all result slots read zero, and end-of-scan, busy, every sample strobe and every convert strobe are low.
- R2: Slot 0 is written on the 17th rising edge after the edge that accepts the start pulse (8.5 converter clocks at two cycles per converter clock).
- R3: Each later conversion of the same scan completes, and writes its slot or slots, 12 edges after the previous one.
- R4: With `simul_i` low, every conversion runs on core 0. Slot k is filled in order k = 0, 1, ... and is converted from the channel in `sel_i[3k+2:3k]`.
- R5: With `simul_i` high, slots 2p and 2p+1 are converted together: core 0 takes slot 2p and core 1 takes slot 2p+1, and both sample strobes rise on the same cycle. A full scan of eight ends 53 edges after start (26.5 converter clocks). For an odd length, core 1 stays idle in the last pair.
- R6: `len_i` holds the number of slots minus one (0 to 7). Slots at or above that count keep their previous values.
- R7: `eos_o` is high for exactly one cycle. That cycle is the first one in which the last slot's new value is visible.
- R8: `busy_o` is high from the cycle after an accepted start until the end-of-scan cycle, in which it is low unless looping. A start pulse while busy is ignored and does not change the scan's timing or contents.
- R9: If `loop_i` is high on the completion edge of the last slot, slot 0 of the next scan is written 12 edges later. Looping stops at the first end-of-scan edge on which `loop_i` is low.
- R10: On every active core, the sample strobe is high in the first cycle of each conversion and the convert strobe in the second. The channel select is held for the whole conversion. The slot captures that core's `code_i` word on the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, twice the converter clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Scan start request, accepted only when idle |
| simul_i | input | 1 | 1: paired simultaneous mode, 0: sequential on core 0 |
| loop_i | input | 1 | Repeat scans while high |
| len_i | input | 3 | Number of slots minus one |
| sel_i | input | 24 | Channel for slot k in bits [3k+2:3k] |
| samp_o | output | 2 | Sample strobe, bit c for core c |
| conv_o | output | 2 | Convert strobe, bit c for core c |
| mux_o | output | 6 | Channel select, core c in bits [3c+2:3c] |
| code_i | input | 24 | Returned code, core c in bits [12c+11:12c] |
| res_o | output | 96 | Result slot k in bits [12k+11:12k] |
| eos_o | output | 1 | End-of-scan pulse |
| busy_o | output | 1 | Scan in progress |

## Verification
The bench sweeps every scan length in both modes. For each slot it checks the edge before the write and the edge of the write. A first conversion that used the 12-cycle spacing, or a later one that reused 17 cycles, shows up as a slot changing one edge early or a full step late. Paired scans of odd length catch a core 1 that converts past the end of the list and corrupts an untouched slot, or that is counted with a wrong number of sample strobes. A start pulse sent in mid-scan exposes a sequencer that restarts or reloads its configuration. The loop run checks that the next scan's first slot arrives 12 edges after end-of-scan rather than 17, and that clearing `loop_i` stops the block after the current scan.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int unsigned SLOTS    = 8;
  localparam int unsigned RES_W    = 12;
  localparam int unsigned CH_W     = 3;
  localparam int unsigned FIRST_HC = 17;  // 8.5 converter clocks
  localparam int unsigned NEXT_HC  = 12;  // 6 converter clocks
  typedef enum logic {ST_IDLE, ST_RUN} scan_st_e;
endpackage

// File: rtl/scan_seq_timer.sv
module scan_seq_timer #(
  parameter int unsigned FIRST_HC = 17,
  parameter int unsigned NEXT_HC  = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic first_i,
  input  logic run_i,
  output logic done_o,
  output logic fresh_o
);
  localparam int unsigned MAX_HC = (FIRST_HC > NEXT_HC) ? FIRST_HC : NEXT_HC;
  localparam int unsigned CW     = $clog2(MAX_HC);

  logic [CW-1:0] cnt_q;
  logic          fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= load_i;
      if (load_i)
        cnt_q <= first_i ? CW'(FIRST_HC - 1) : CW'(NEXT_HC - 1);
      else if (run_i && cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fresh_o = fresh_q;
  assign done_o  = run_i && (cnt_q == '0) && !fresh_q;
endmodule

// File: rtl/scan_seq_core.sv
module scan_seq_core #(
  parameter int unsigned CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fresh_i,
  input  logic            active_i,
  input  logic [CH_W-1:0] sel_i,
  output logic            samp_o,
  output logic            conv_o,
  output logic [CH_W-1:0] mux_o
);
  logic conv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conv_q <= 1'b0;
    else         conv_q <= samp_o;
  end

  assign samp_o = fresh_i & active_i;
  assign conv_o = conv_q;
  assign mux_o  = active_i ? sel_i : '0;
endmodule

// File: rtl/scan_seq_store.sv
module scan_seq_store #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned RES_W = 12,
  parameter int unsigned IDX_W = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 wr_i,
  input  logic [1:0][IDX_W-1:0]      idx_i,
  input  logic [1:0][RES_W-1:0]      code_i,
  output logic [SLOTS*RES_W-1:0]     res_o
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [RES_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q <= '0;
      else if (wr_i[0] && idx_i[0] == IDX_W'(k))   slot_q <= code_i[0];
      else if (wr_i[1] && idx_i[1] == IDX_W'(k))   slot_q <= code_i[1];
    end
    assign res_o[k*RES_W +: RES_W] = slot_q;
  end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int unsigned SLOTS    = scan_seq_pkg::SLOTS,
  parameter int unsigned RES_W    = scan_seq_pkg::RES_W,
  parameter int unsigned CH_W     = scan_seq_pkg::CH_W,
  parameter int unsigned FIRST_HC = scan_seq_pkg::FIRST_HC,
  parameter int unsigned NEXT_HC  = scan_seq_pkg::NEXT_HC
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      simul_i,
  input  logic                      loop_i,
  input  logic [$clog2(SLOTS)-1:0]  len_i,
  input  logic [SLOTS*CH_W-1:0]     sel_i,
  output logic [1:0]                samp_o,
  output logic [1:0]                conv_o,
  output logic [2*CH_W-1:0]         mux_o,
  input  logic [2*RES_W-1:0]        code_i,
  output logic [SLOTS*RES_W-1:0]    res_o,
  output logic                      eos_o,
  output logic                      busy_o
);
  localparam int unsigned IDX_W = $clog2(SLOTS);
  localparam int unsigned NXT_W = IDX_W + 1;

  scan_st_e              st_q;
  logic                  simul_q, eos_q;
  logic [IDX_W-1:0]      last_q, slot_q;
  logic [SLOTS*CH_W-1:0] sel_q;

  logic                  accept, scan_end, pair_ok;
  logic                  tmr_done, tmr_fresh, tmr_load;
  logic [NXT_W-1:0]      slot1, slot_nx;
  logic [1:0]            active, wr;
  logic [1:0][IDX_W-1:0] idx;
  logic [1:0][RES_W-1:0] code_w;

  assign accept   = (st_q == ST_IDLE) && start_i;
  assign slot1    = NXT_W'(slot_q) + NXT_W'(1);
  assign pair_ok  = simul_q && (slot1 <= NXT_W'(last_q));
  assign slot_nx  = NXT_W'(slot_q) + (simul_q ? NXT_W'(2) : NXT_W'(1));
  assign scan_end = tmr_done && (slot_nx > NXT_W'(last_q));
  assign tmr_load = accept || (tmr_done && (!scan_end || loop_i));

  assign active[0] = (st_q == ST_RUN);
  assign active[1] = (st_q == ST_RUN) && pair_ok;
  assign idx[0]    = slot_q;
  assign idx[1]    = slot1[IDX_W-1:0];
  assign wr        = {2{tmr_done}} & active;
  assign code_w    = code_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      simul_q <= 1'b0;
      last_q  <= '0;
      slot_q  <= '0;
      sel_q   <= '0;
      eos_q   <= 1'b0;
    end else begin
      eos_q <= scan_end;
      if (accept) begin
        st_q    <= ST_RUN;
        simul_q <= simul_i;
        last_q  <= len_i;
        sel_q   <= sel_i;
        slot_q  <= '0;
      end else if (tmr_done) begin
        if (scan_end) begin
          slot_q <= '0;
          if (!loop_i) st_q <= ST_IDLE;
        end else begin
          slot_q <= slot_nx[IDX_W-1:0];
        end
      end
    end
  end

  scan_seq_timer #(.FIRST_HC(FIRST_HC), .NEXT_HC(NEXT_HC)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .first_i (accept),
    .run_i   (st_q == ST_RUN),
    .done_o  (tmr_done),
    .fresh_o (tmr_fresh)
  );

  for (genvar c = 0; c < 2; c++) begin : g_core
    scan_seq_core #(.CH_W(CH_W)) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fresh_i  (tmr_fresh),
      .active_i (active[c]),
      .sel_i    (sel_q[int'(idx[c])*CH_W +: CH_W]),
      .samp_o   (samp_o[c]),
      .conv_o   (conv_o[c]),
      .mux_o    (mux_o[c*CH_W +: CH_W])
    );
  end

  scan_seq_store #(.SLOTS(SLOTS), .RES_W(RES_W), .IDX_W(IDX_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .idx_i  (idx),
    .code_i (code_w),
    .res_o  (res_o)
  );

  assign eos_o  = eos_q;
  assign busy_o = (st_q == ST_RUN);
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int unsigned CH_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [1:0]      samp_o,
  input logic [1:0]      conv_o,
  input logic [2*CH_W-1:0] mux_o,
  input logic            eos_o,
  input logic            busy_o,
  input logic            simul_q
);
  assert_eos_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |=> !eos_o);

  assert_busy_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_busy_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> eos_o);

  assert_seq_core0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !simul_q) |-> !samp_o[1]);

  assert_pair_sample_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o[1] |-> (samp_o[0] && simul_q));

  assert_conv0_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o[0] |=> conv_o[0]);

  assert_conv1_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o[1] |=> conv_o[1]);

  assert_mux_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !samp_o[0]) |-> $stable(mux_o));
endmodule

bind scan_seq scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .samp_o  (samp_o),
  .conv_o  (conv_o),
  .mux_o   (mux_o),
  .eos_o   (eos_o),
  .busy_o  (busy_o),
  .simul_q (simul_q)
);

// File: tb/scan_seq_tb_top.sv
module scan_seq_tb_top;
  localparam int SLOTS = 8;
  localparam int RES_W = 12;
  localparam int CH_W  = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, simul_i = 1'b0, loop_i = 1'b0;
  logic [2:0]             len_i = '0;
  logic [SLOTS*CH_W-1:0]  sel_i = '0;
  logic [1:0]             samp_o, conv_o;
  logic [2*CH_W-1:0]      mux_o;
  logic [2*RES_W-1:0]     code_i = '0;
  logic [SLOTS*RES_W-1:0] res_o;
  logic                   eos_o, busy_o;

  int vec = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0]       tag = 8'd0;
  logic [RES_W-1:0] exp_res [SLOTS];

  always #10 clk_i = ~clk_i;

  scan_seq dut_i (
    .clk_i, .rst_ni, .start_i, .simul_i, .loop_i, .len_i, .sel_i,
    .samp_o, .conv_o, .mux_o, .code_i, .res_o, .eos_o, .busy_o
  );

  // converter stand-in: code = {core, channel, tag}, latched on convert strobe
  always @(negedge clk_i) begin
    for (int c = 0; c < 2; c++)
      if (conv_o[c]) code_i[c*RES_W +: RES_W] <= {c[0], mux_o[c*CH_W +: CH_W], tag};
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [RES_W-1:0] slot(input int k);
    return res_o[k*RES_W +: RES_W];
  endfunction

  task automatic run_scan(input bit sim, input int n_sl, input bit poke);
    int wr_cyc [SLOTS];
    logic [RES_W-1:0] nv [SLOTS];
    logic [SLOTS*CH_W-1:0] sel;
    int last, eos_err, busy_err, s0, s1;
    tag = tag + 8'd1;
    for (int k = 0; k < SLOTS; k++) sel[k*CH_W +: CH_W] = 3'((k*3 + int'(tag)) % 8);
    for (int k = 0; k < n_sl; k++) begin
      wr_cyc[k] = sim ? 17 + 12*(k/2) : 17 + 12*k;
      nv[k]     = {(sim && (k % 2 == 1)), sel[k*CH_W +: CH_W], tag};
    end
    last = wr_cyc[n_sl-1];
    eos_err = 0; busy_err = 0; s0 = 0; s1 = 0;
    @(negedge clk_i);
    simul_i = sim; len_i = 3'(n_sl-1); sel_i = sel; loop_i = 1'b0; start_i = 1'b1;
    for (int n = 0; n <= last + 2; n++) begin
      @(negedge clk_i);
      // R8: mid-scan start requests with a different configuration
      start_i = poke && (n == 5 || n == 30) && (n < last);
      if (start_i) begin simul_i = ~sim; len_i = 3'd0; sel_i = ~sel; end
      s0 += int'(samp_o[0]);
      s1 += int'(samp_o[1]);
      for (int k = 0; k < n_sl; k++) begin
        if (n == wr_cyc[k] - 1)
          chk(slot(k) == exp_res[k], k == 0 ? "R2 early write" : "R3 early write",
              slot(k), exp_res[k]);
        if (n == wr_cyc[k])
          chk(slot(k) == nv[k], sim ? "R5 slot value" : (k == 0 ? "R2 R4 slot value" : "R3 R4 slot value"),
              slot(k), nv[k]);
      end
      if (eos_o != (n == last)) eos_err++;
      if (busy_o != (n < last)) busy_err++;
    end
    start_i = 1'b0;
    chk(eos_err == 0, "R7 eos cycle", eos_err, 0);
    chk(busy_err == 0, "R8 busy window", busy_err, 0);
    chk(s0 == (sim ? (n_sl+1)/2 : n_sl), "R10 core0 samples", s0, sim ? (n_sl+1)/2 : n_sl);
    chk(s1 == (sim ? n_sl/2 : 0), "R5 core1 samples", s1, sim ? n_sl/2 : 0);
    for (int k = n_sl; k < SLOTS; k++)
      chk(slot(k) == exp_res[k], "R6 untouched slot", slot(k), exp_res[k]);
    for (int k = 0; k < n_sl; k++) exp_res[k] = nv[k];
  endtask

  task automatic loop_test();
    logic [RES_W-1:0] v1 [3], v2 [3];
    int eos_err, busy_err;
    logic [SLOTS*CH_W-1:0] sel;
    eos_err = 0; busy_err = 0;
    tag = tag + 8'd1;
    for (int k = 0; k < SLOTS; k++) sel[k*CH_W +: CH_W] = 3'(7 - k);
    for (int k = 0; k < 3; k++) begin
      v1[k] = {1'b0, sel[k*CH_W +: CH_W], tag};
      v2[k] = {1'b0, sel[k*CH_W +: CH_W], tag + 8'd1};
    end
    @(negedge clk_i);
    simul_i = 1'b0; len_i = 3'd2; sel_i = sel; loop_i = 1'b1; start_i = 1'b1;
    for (int n = 0; n <= 80; n++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (n == 41) begin tag = tag + 8'd1; loop_i = 1'b0; end
      if (n == 17) chk(slot(0) == v1[0], "R9 scan1 slot0", slot(0), v1[0]);
      if (n == 41) chk(slot(2) == v1[2], "R9 scan1 slot2", slot(2), v1[2]);
      if (n == 52) chk(slot(0) == v1[0], "R9 wrap early", slot(0), v1[0]);
      if (n == 53) chk(slot(0) == v2[0], "R9 wrap spacing", slot(0), v2[0]);
      if (n == 65) chk(slot(1) == v2[1], "R9 scan2 slot1", slot(1), v2[1]);
      if (n == 77) chk(slot(2) == v2[2], "R9 scan2 slot2", slot(2), v2[2]);
      if (eos_o != (n == 41 || n == 77)) eos_err++;
      if (busy_o != (n < 77)) busy_err++;
    end
    chk(eos_err == 0, "R9 eos pulses", eos_err, 0);
    chk(busy_err == 0, "R9 loop stop", busy_err, 0);
    for (int k = 0; k < 3; k++) exp_res[k] = v2[k];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    vec++; bad++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < SLOTS; k++) exp_res[k] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(res_o == '0, "R1 results", 0, 0);
    chk({eos_o, busy_o, samp_o, conv_o} == '0, "R1 controls",
        {eos_o, busy_o, samp_o, conv_o}, 0);
    for (int m = 0; m < 2; m++)
      for (int l = 1; l <= SLOTS; l++)
        run_scan(m[0], l, l >= 6);
    loop_test();
    run_scan(1'b1, 3, 1'b0);
    run_scan(1'b0, 2, 1'b0);
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule